// File: doc/BRIEF.md
# Two-Level Page Table Walker with Translation Cache

This block turns 32-bit virtual addresses into physical addresses. Each request first looks in a small fully associative translation cache. On a miss, hardware reads two table entries through a memory read port: a directory entry, then a second-level entry. It then installs the translation and answers with the physical address. If it cannot translate, it answers with a fault and a cause code.

A base register holds the address of the current directory. Rewriting that register switches to another address space and empties the translation cache. A separate flush pin also empties the cache.

Requests and responses use valid/ready handshakes, and only one request is in flight at a time:
- `req_ready` is high only while the block is idle.
- A response stays on the outputs, unchanged, until `rsp_ready` accepts it.
- On the memory side, a read request holds its address until `mem_rd_ready` is seen.
- The read data comes back some cycles later as a single `mem_rsp_valid` pulse, and that pulse cannot be back-pressured.

Top module: `pt_walker`

## Requirements
- R1: The virtual address splits into three fields. Bits 31..22 index the directory, bits 21..12 index the second-level table, and bits 11..0 pass through unchanged as the low bits of the physical address. The directory entry is read at base + index*4. The second-level entry is read at {directory entry bits 31..12, 12'h000} + index*4. The physical address is {second-level entry bits 31..12, offset}.
- R2: A request whose page number is in the translation cache is answered without any memory read.
- R3: A cache miss performs exactly two memory reads, directory first and table second. A read address is held until its handshake completes.
- R4: An entry with bit 0 (present) clear ends the walk with a fault of cause 1. A directory fault issues one read and a table fault issues two. On a fault, `rsp_paddr` is zero. Cause 0 means success and `rsp_fault` is high exactly when the cause is non-zero.
- R5: A write to a page whose table entry has bit 1 (writable) clear faults with cause 2. This applies both after a walk and on a cache hit. Reads of such a page succeed.
- R6: A faulting request installs nothing, so repeating it walks again.
- R7: A successful walk installs the translation. The cache holds 8 entries, and the victim is chosen by a round-robin pointer that advances on each install.
- R8: The `flush` pin invalidates every cache entry but leaves the round-robin pointer where it is.
- R9: Writing the base register flushes the cache, and later walks start from the new base.
- R10: `req_ready` is low from the accepted request until its response is taken. A response held with `rsp_ready` low keeps its valid, address, fault and cause stable.
- R11: After reset:
  - `req_ready` is 1;
  - `rsp_valid` and `mem_rd_valid` are 0;
  - the base is 0;
  - the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_paddr | output | 32 | Physical address (zero on a fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 write to read-only page |
| base_we | input | 1 | Load the directory base register (also flushes the cache) |
| base_wdata | input | 32 | New directory base address |
| flush | input | 1 | Invalidate all cache entries |
| mem_rd_valid | output | 1 | Entry read request valid |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 32 | Entry address |
| mem_rsp_valid | input | 1 | Read data valid (one pulse per read) |
| mem_rsp_data | input | 32 | Entry read data |

## Verification
The assertions take three things for granted about the inputs:
- the memory returns exactly one data pulse for each accepted read, and never one without a read;
- the base register is rewritten only while no request is in flight;
- `flush` never coincides with an install.

The stimulus keeps to these. A responder holds at most one read pending, with latency varying between one and three cycles and read-ready dropped on a fixed pattern. Base writes and flushes are issued only between completed transactions.

Each response is compared against a behavioural model with its own table memory and eight-slot cache. The comparison covers the address, the cause and the exact list of read addresses. Response back-pressure is applied on every transaction.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int PRESENT_BIT  = 0;
  localparam int WRITABLE_BIT = 1;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_RDONLY = 2'd2
  } xlate_cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_TBL_REQ,
    ST_TBL_WAIT,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/pw_tlb.sv
module pw_tlb #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_wr,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_wr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             ent_v   [DEPTH];
  logic             ent_w   [DEPTH];
  logic [VPN_W-1:0] ent_vpn [DEPTH];
  logic [PFN_W-1:0] ent_pfn [DEPTH];
  logic [DEPTH-1:0] match;
  logic [PTR_W-1:0] ptr;

  // Round-robin victim pointer: advances on each install, unaffected by flush.
  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (fill_en && !flush) ptr <= (ptr == PTR_W'(DEPTH-1)) ? '0 : ptr + 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign match[i] = ent_v[i] && (ent_vpn[i] == lk_vpn);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_v[i]   <= 1'b0;
        ent_w[i]   <= 1'b0;
        ent_vpn[i] <= '0;
        ent_pfn[i] <= '0;
      end else if (flush) begin
        ent_v[i] <= 1'b0;
      end else if (fill_en && ptr == PTR_W'(i)) begin
        ent_v[i]   <= 1'b1;
        ent_w[i]   <= fill_wr;
        ent_vpn[i] <= fill_vpn;
        ent_pfn[i] <= fill_pfn;
      end
    end
  end

  // At most one entry can match, so an OR of the masked entries selects it.
  always_comb begin
    lk_pfn = '0;
    lk_wr  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) begin
        lk_pfn = lk_pfn | ent_pfn[i];
        lk_wr  = lk_wr | ent_w[i];
      end
    end
  end

  assign lk_hit = |match;
endmodule

// File: rtl/pw_walk_fsm.sv
module pw_walk_fsm
  import pw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int DIR_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_vaddr,
  input  logic                    req_write,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [ADDR_W-1:0]       rsp_paddr,
  output logic [1:0]              rsp_cause,
  input  logic [ADDR_W-1:0]       base_addr,
  output logic [ADDR_W-OFF_W-1:0] lk_vpn,
  input  logic                    lk_hit,
  input  logic [ADDR_W-OFF_W-1:0] lk_pfn,
  input  logic                    lk_wr,
  output logic                    fill_en,
  output logic [ADDR_W-OFF_W-1:0] fill_vpn,
  output logic [ADDR_W-OFF_W-1:0] fill_pfn,
  output logic                    fill_wr,
  output logic                    mem_rd_valid,
  input  logic                    mem_rd_ready,
  output logic [ADDR_W-1:0]       mem_rd_addr,
  input  logic                    mem_rsp_valid,
  input  logic [ADDR_W-1:0]       mem_rsp_data
);
  localparam int TBL_W = ADDR_W - OFF_W - DIR_W;
  localparam int PFN_W = ADDR_W - OFF_W;

  walk_st_e          st;
  xlate_cause_e      cause_q;
  logic [ADDR_W-1:0] va_q;
  logic              wr_q;
  logic [PFN_W-1:0]  tbl_pfn_q;
  logic [ADDR_W-1:0] paddr_q;

  logic [DIR_W-1:0]  dir_idx;
  logic [TBL_W-1:0]  tbl_idx;
  logic [OFF_W-1:0]  offset;
  logic [ADDR_W-1:0] dir_addr, tbl_addr;
  logic              ent_p, ent_w;
  logic [PFN_W-1:0]  ent_pfn;
  logic              unused_ent_bits;

  assign dir_idx = va_q[ADDR_W-1 -: DIR_W];
  assign tbl_idx = va_q[OFF_W +: TBL_W];
  assign offset  = va_q[OFF_W-1:0];
  assign lk_vpn  = va_q[ADDR_W-1:OFF_W];

  assign ent_p   = mem_rsp_data[PRESENT_BIT];
  assign ent_w   = mem_rsp_data[WRITABLE_BIT];
  assign ent_pfn = mem_rsp_data[ADDR_W-1:OFF_W];
  assign unused_ent_bits = ^mem_rsp_data[OFF_W-1:2];

  assign dir_addr = base_addr + ADDR_W'({dir_idx, 2'b00});
  assign tbl_addr = {tbl_pfn_q, {OFF_W{1'b0}}} + ADDR_W'({tbl_idx, 2'b00});

  assign req_ready    = (st == ST_IDLE);
  assign rsp_valid    = (st == ST_RESP);
  assign rsp_paddr    = paddr_q;
  assign rsp_cause    = cause_q;
  assign mem_rd_valid = (st == ST_DIR_REQ) || (st == ST_TBL_REQ);
  assign mem_rd_addr  = (st == ST_TBL_REQ) ? tbl_addr : dir_addr;

  assign fill_en  = (st == ST_TBL_WAIT) && mem_rsp_valid && ent_p && !(wr_q && !ent_w);
  assign fill_vpn = va_q[ADDR_W-1:OFF_W];
  assign fill_pfn = ent_pfn;
  assign fill_wr  = ent_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cause_q   <= CAUSE_NONE;
      va_q      <= '0;
      wr_q      <= 1'b0;
      tbl_pfn_q <= '0;
      paddr_q   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          wr_q <= req_write;
          st   <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (lk_hit) begin
            if (wr_q && !lk_wr) begin
              cause_q <= CAUSE_RDONLY;
              paddr_q <= '0;
            end else begin
              cause_q <= CAUSE_NONE;
              paddr_q <= {lk_pfn, offset};
            end
            st <= ST_RESP;
          end else begin
            st <= ST_DIR_REQ;
          end
        end
        ST_DIR_REQ: if (mem_rd_ready) st <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (mem_rsp_valid) begin
          if (!ent_p) begin
            cause_q <= CAUSE_ABSENT;
            paddr_q <= '0;
            st      <= ST_RESP;
          end else begin
            tbl_pfn_q <= ent_pfn;
            st        <= ST_TBL_REQ;
          end
        end
        ST_TBL_REQ: if (mem_rd_ready) st <= ST_TBL_WAIT;
        ST_TBL_WAIT: if (mem_rsp_valid) begin
          if (!ent_p) begin
            cause_q <= CAUSE_ABSENT;
            paddr_q <= '0;
          end else if (wr_q && !ent_w) begin
            cause_q <= CAUSE_RDONLY;
            paddr_q <= '0;
          end else begin
            cause_q <= CAUSE_NONE;
            paddr_q <= {ent_pfn, offset};
          end
          st <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int DIR_W     = 10,
  parameter int TLB_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              flush,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data
);
  localparam int PN_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] base_q;
  logic [PN_W-1:0]   lk_vpn, lk_pfn, fill_vpn, fill_pfn;
  logic              lk_hit, lk_wr, fill_en, fill_wr;

  // Directory base register; any write also empties the translation cache.
  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

  pw_tlb #(.VPN_W(PN_W), .PFN_W(PN_W), .DEPTH(TLB_DEPTH)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush | base_we),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_wr(lk_wr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_wr(fill_wr)
  );

  pw_walk_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DIR_W(DIR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause),
    .base_addr(base_q),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_wr(lk_wr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_wr(fill_wr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  assign rsp_fault = (rsp_cause != 2'd0);
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int AW    = 32,
  parameter int OFF_W = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_vaddr,
  input logic          req_write,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_paddr,
  input logic          rsp_fault,
  input logic [1:0]    rsp_cause,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [AW-1:0] mem_rd_addr
);
  localparam logic [AW-1:0] OFF_MASK = AW'((64'd1 << OFF_W) - 64'd1);

  logic [AW-1:0] va_cap;
  logic          wr_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_cap <= '0;
      wr_cap <= 1'b0;
    end else if (req_valid && req_ready) begin
      va_cap <= req_vaddr;
      wr_cap <= req_write;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_cause) && $stable(rsp_fault)); // R10
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R10
  AST_MEM_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R3
  AST_NO_READ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_valid); // R10
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)) && (rsp_cause != 2'd3)); // R4
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0); // R4
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> ((rsp_paddr ^ va_cap) & OFF_MASK) == '0); // R1
  AST_WP_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cause == 2'd2 |-> wr_cap); // R5
endmodule

bind pt_walker pw_checker #(.AW(ADDR_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_vaddr;
  logic        rsp_valid, rsp_ready, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_cause;
  logic        base_we, flush;
  logic [31:0] base_wdata;
  logic        mem_rd_valid, mem_rd_ready, mem_rsp_valid;
  logic [31:0] mem_rd_addr, mem_rsp_data;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pt_walker u0 (.*);

  // ---------------- table memory and read responder ----------------
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log[$];
  logic [31:0] pend_addr;
  bit          pend = 0;
  int          lat = 0, nrd = 0, cyc = 0;

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  initial begin
    mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      mem_rsp_data  = 0;
      if (pend) begin
        lat--;
        if (lat == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data  = mem_rd(pend_addr);
          pend = 0;
        end
      end
      mem_rd_ready = !pend && (cyc % 3 != 1);
      if (rst_n && mem_rd_valid && mem_rd_ready) begin
        pend = 1; pend_addr = mem_rd_addr; lat = 1 + (nrd % 3); nrd++;
        rd_log.push_back(mem_rd_addr);
      end
      cyc++;
    end
  end

  // ---------------- reference model ----------------
  logic [31:0] m_base = 0;
  logic [19:0] m_vpn [8];
  logic [19:0] m_pfn [8];
  bit          m_v [8];
  bit          m_w [8];
  int          m_ptr = 0;
  logic [31:0] exp_q[$];

  task automatic m_flush();
    for (int i = 0; i < 8; i++) m_v[i] = 0;
  endtask

  task automatic model(input logic [31:0] va, input bit wr,
                       output logic [31:0] pa, output logic [1:0] cause);
    bit hit = 0;
    logic [31:0] d, e, ta;
    exp_q.delete();
    pa = 0; cause = 0;
    for (int i = 0; i < 8; i++) begin
      if (m_v[i] && m_vpn[i] == va[31:12]) begin
        hit = 1;
        if (wr && !m_w[i]) cause = 2;
        else pa = {m_pfn[i], va[11:0]};
      end
    end
    if (!hit) begin
      ta = m_base + {20'h0, va[31:22], 2'b00};
      exp_q.push_back(ta);
      d = mem_rd(ta);
      if (!d[0]) cause = 1;
      else begin
        ta = {d[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
        exp_q.push_back(ta);
        e = mem_rd(ta);
        if (!e[0]) cause = 1;
        else if (wr && !e[1]) cause = 2;
        else begin
          pa = {e[31:12], va[11:0]};
          m_v[m_ptr] = 1; m_w[m_ptr] = e[1];
          m_vpn[m_ptr] = va[31:12]; m_pfn[m_ptr] = e[31:12];
          m_ptr = (m_ptr + 1) % 8;
        end
      end
    end
  endtask

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic map(input logic [31:0] base, input logic [31:0] va, input logic [19:0] tf,
                     input logic [19:0] pfn, input bit w);
    mem[base + {20'h0, va[31:22], 2'b00}] = {tf, 12'h001};
    mem[{tf, 12'h0} + {20'h0, va[21:12], 2'b00}] = {pfn, 10'h0, w, 1'b1};
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk); base_we = 1; base_wdata = b;
    @(negedge clk); base_we = 0;
    m_base = b; m_flush();
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    m_flush();
  endtask

  task automatic access(input string tag, input logic [31:0] va, input bit wr);
    logic [31:0] epa, apa;
    logic [1:0]  ec, ac;
    logic        af;
    model(va, wr, epa, ec);
    rd_log.delete();
    @(negedge clk); req_valid = 1; req_vaddr = va; req_write = wr;
    @(negedge clk); req_valid = 0;
    chk("R10", "req_ready while busy", {31'h0, req_ready}, 32'h0);
    while (!rsp_valid) @(negedge clk);
    apa = rsp_paddr; ac = rsp_cause; af = rsp_fault;
    repeat (2) @(negedge clk);
    chk("R10", "held response", {rsp_valid, rsp_paddr[30:0] ^ apa[30:0]}, 32'h80000000);
    chk("R10", "held cause", {29'h0, rsp_fault, rsp_cause}, {29'h0, af, ac});
    rsp_ready = 1;
    @(negedge clk); rsp_ready = 0;
    chk(tag, "cause", {30'h0, ac}, {30'h0, ec});
    chk("R4", "fault flag", {31'h0, af}, {31'h0, ec != 0});
    chk(tag, "paddr", apa, epa);
    chk(tag, "read count", rd_log.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < rd_log.size(); i++)
      chk(tag, "read address", rd_log[i], exp_q[i]);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 0; req_valid = 0; req_vaddr = 0; req_write = 0; rsp_ready = 0;
    base_we = 0; base_wdata = 0; flush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "req_ready", {31'h0, req_ready}, 32'h1);
    chk("R11", "rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R11", "mem_rd_valid", {31'h0, mem_rd_valid}, 32'h0);

    map(32'h0010_0000, 32'h0040_1234, 20'h00201, 20'h0ABCD, 1);
    map(32'h0010_0000, 32'h0040_2ABC, 20'h00201, 20'h12345, 0);
    map(32'h0010_0000, 32'hFFC0_3FFC, 20'h00203, 20'hFFFFF, 1);
    for (int i = 0; i < 9; i++)
      map(32'h0010_0000, 32'h0080_0000 + (i << 12), 20'h00202, 20'h40000 + 20'(i), 1);
    map(32'h0030_0000, 32'h0040_1234, 20'h00400, 20'h55555, 1);
    set_base(32'h0010_0000);

    access("R3", 32'h0040_1234, 0);   // miss: two reads
    access("R2", 32'h0040_1234, 0);   // hit: no reads
    access("R2", 32'h0040_1238, 1);   // write hit on writable page
    access("R5", 32'h0040_2ABC, 1);   // write to read-only after walk
    access("R6", 32'h0040_2ABC, 0);   // fault installed nothing: walks again
    access("R5", 32'h0040_2AB0, 1);   // write to read-only on hit
    access("R4", 32'h8000_0000, 0);   // directory entry absent
    access("R4", 32'h0040_5000, 0);   // table entry absent
    access("R6", 32'h0040_5000, 0);   // walks again
    access("R1", 32'hFFC0_3FFC, 1);   // top directory index, offset boundary

    do_flush();
    access("R8", 32'h0040_1234, 0);   // misses after flush
    for (int i = 0; i < 9; i++) access("R7", 32'h0080_0000 + (i << 12) + 32'(i * 4), 0);
    access("R7", 32'h0080_0010, 0);   // evicted by round robin
    access("R7", 32'h0080_8000, 0);   // still resident

    set_base(32'h0030_0000);
    access("R9", 32'h0040_1234, 0);   // new space, new frame
    access("R9", 32'h0040_2ABC, 0);   // unmapped in new space

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule